// File: doc/BRIEF.md
# Erasable ROM Mode Decoder with Identifier Readout

This block is a clock-synchronous model of the control and output path of a 16K x 8 ultraviolet-erasable read-only memory. It watches chip select, output gate and program strobe, plus two decoded high-voltage flags: one for the programming supply pin and one for address line 9. From these it settles the operating mode once per cycle. The result is one of standby, program, output off, identifier or read. In the read-type modes it drives the data bus with either array contents or a fixed identifier byte. In program mode it takes the bus as input and clears bits in the addressed location.

The analog parts of a real part are reduced to flags and cycle counts. The high-impedance state of the bus is shown by a separate drive flag. Access time after chip select, the shorter access time after output gate, and the float time after either one is released are each a parameter counted in clock cycles. The storage array keeps `2**ARRAY_AW` locations. Only the low address bits pick a location, which keeps elaboration small, and the upper address bits alias onto it. A separate erase input returns every location to all ones. The data bus is a plain level interface with no handshake. The block can refuse nothing and stall nothing, so it applies no back-pressure.

Top module: `eprom_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `dout_en` is 0 and `dout` is 0x00, and every array location holds 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `a9_hv`=0 and no program strobe, the block presents on `dout` the byte stored at location `addr[ARRAY_AW-1:0]`. An address change shows one cycle later.
- R3: With `oe_n` already low, `dout_en` first rises on the (T_CE+1)-th rising edge after `ce_n` falls. With `ce_n` already low, it first rises on the (T_OE+1)-th rising edge after `oe_n` falls.
- R4: When a read-type mode ends, `dout_en` stays 1 for T_DF-1 more edges and drops on the T_DF-th edge, with `dout` holding its last value.
- R5: `ce_n`=1 selects standby. The outputs float after the float delay whatever `oe_n` is.
- R6: `ce_n`=0 with `oe_n`=1 floats the outputs after the float delay.
- R7: With `a9_hv`=1, `ce_n`=0, `oe_n`=0 and no program strobe, `addr[0]`=0 gives 0x01 and `addr[0]`=1 gives 0x16. All other address bits are ignored.
- R8: Every identifier byte has odd parity over all 8 bits, with bit 7 as the parity bit.
- R9: `vpp_hv`=1, `ce_n`=0 and `pgm_n`=0 select program mode. On each such edge the addressed location becomes old AND `din`, so a 1 is never restored. The outputs float, even with `oe_n` low.
- R10: `vpp_hv`=1 with `ce_n`=1 inhibits programming. The array is unchanged and the outputs float.
- R11: `vpp_hv`=1 with `pgm_n`=1, `ce_n`=0 and `oe_n`=0 reads the array back as in R2.
- R12: A cycle with `erase`=1 sets every location to 0xFF from the next edge on.
- R13: Address bits above `ARRAY_AW-1` do not affect which location is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hv | input | 1 | Programming supply at high voltage |
| a9_hv | input | 1 | Address line 9 at high voltage (identifier request) |
| erase | input | 1 | Set every location to 0xFF |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data in program mode |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Bus driven (0 means high impedance) |

## Verification
The bench drives a read from an erased location after chip select falls, and separately after output gate falls. These two cases tell the long access delay from the short one. Two program pulses with overlapping bit patterns show that programming only clears bits. A program attempt with chip select high shows that inhibit really blocks the write. Address patterns with high bits set separate aliasing from real decoding. In the identifier mode, `addr[0]` is toggled with the other address bits both clear and set. Leaving read mode through standby, through output off and through program mode shows that every exit waits the same float delay. A final erase returns programmed locations to all ones.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_PROGRAM,
    MD_OUTOFF,
    MD_IDENT,
    MD_READ
  } mode_t;

  // bit 7 chosen so the whole byte has an odd number of ones
  function automatic logic [DATA_W-1:0] odd_par_byte(input logic [DATA_W-2:0] lo);
    return {~^lo, lo};
  endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hv,
  input  logic  a9_hv,
  output mode_t mode,
  output logic  wr_en,
  output logic  rd_type
);
  always_comb begin
    if (ce_n)                 mode = MD_STANDBY;
    else if (vpp_hv && !pgm_n) mode = MD_PROGRAM;
    else if (oe_n)            mode = MD_OUTOFF;
    else if (a9_hv)           mode = MD_IDENT;
    else                      mode = MD_READ;
  end

  assign wr_en   = (mode == MD_PROGRAM);
  assign rd_type = (mode == MD_IDENT) || (mode == MD_READ);
endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ARRAY_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [ARRAY_AW-1:0] idx;

  assign idx = addr[ARRAY_AW-1:0];

  generate
    if (ADDR_W > ARRAY_AW) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:ARRAY_AW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[idx] <= mem[idx] & wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/eprom_out_timer.sv
module eprom_out_timer #(
  parameter int T_CE = 4,
  parameter int T_OE = 2,
  parameter int T_DF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic rd_type,
  output logic load,
  output logic out_en
);
  localparam int CW = $clog2(T_CE + 1);
  localparam int OW = $clog2(T_OE + 1);
  localparam int HW = (T_DF > 1) ? $clog2(T_DF) : 1;

  logic [CW-1:0] ce_age;
  logic [OW-1:0] oe_age;
  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n || ce_n)              ce_age <= '0;
    else if (ce_age != CW'(T_CE))    ce_age <= ce_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || oe_n)              oe_age <= '0;
    else if (oe_age != OW'(T_OE))    oe_age <= oe_age + 1'b1;
  end

  assign load = rd_type && (ce_age == CW'(T_CE)) && (oe_age == OW'(T_OE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_en <= 1'b0;
      hold   <= '0;
    end else if (load) begin
      out_en <= 1'b1;
      hold   <= '0;
    end else if (out_en) begin
      if (hold == HW'(T_DF - 1)) begin
        out_en <= 1'b0;
        hold   <= '0;
      end else begin
        hold <= hold + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
  import eprom_pkg::*;
#(
  parameter int              ADDR_W   = 14,
  parameter int              ARRAY_AW = 8,
  parameter int              T_CE     = 4,
  parameter int              T_OE     = 2,
  parameter int              T_DF     = 2,
  parameter logic [DATA_W-2:0] MFR_LO = 7'h01,
  parameter logic [DATA_W-2:0] DEV_LO = 7'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hv,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam logic [DATA_W-1:0] MFR_BYTE = odd_par_byte(MFR_LO);
  localparam logic [DATA_W-1:0] DEV_BYTE = odd_par_byte(DEV_LO);

  mode_t             mode;
  logic              wr_en, rd_type, load;
  logic [DATA_W-1:0] rdata, sel;

  eprom_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hv  (vpp_hv),
    .a9_hv   (a9_hv),
    .mode    (mode),
    .wr_en   (wr_en),
    .rd_type (rd_type)
  );

  eprom_array #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (erase),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  eprom_out_timer #(.T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .rd_type (rd_type),
    .load    (load),
    .out_en  (dout_en)
  );

  always_comb begin
    if (mode == MD_IDENT) sel = addr[0] ? DEV_BYTE : MFR_BYTE;
    else                  sel = rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= sel;
  end
endmodule

// File: rtl/eprom_ctl_chk.sv
module eprom_ctl_chk #(
  parameter int ADDR_W = 14,
  parameter int T_CE   = 4,
  parameter int T_DF   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hv,
  input logic              a9_hv,
  input logic [7:0]        dout,
  input logic              dout_en
);
  localparam int CW = $clog2(T_CE + T_DF + 2) + 1;
  localparam logic [CW-1:0] CAP = CW'(T_CE + T_DF + 1);

  logic prog_now, id_now;
  logic [CW-1:0] sb_cnt, off_cnt, pr_cnt, id_cnt;

  assign prog_now = !ce_n && vpp_hv && !pgm_n;
  assign id_now   = !ce_n && !oe_n && a9_hv && !(vpp_hv && !pgm_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_cnt <= '0; off_cnt <= '0; pr_cnt <= '0; id_cnt <= '0;
    end else begin
      sb_cnt  <= ce_n ? ((sb_cnt == CAP) ? CAP : sb_cnt + 1'b1) : '0;
      off_cnt <= (!ce_n && oe_n && !prog_now) ? ((off_cnt == CAP) ? CAP : off_cnt + 1'b1) : '0;
      pr_cnt  <= prog_now ? ((pr_cnt == CAP) ? CAP : pr_cnt + 1'b1) : '0;
      id_cnt  <= id_now ? ((id_cnt == CAP) ? CAP : id_cnt + 1'b1) : '0;
    end
  end

  p_standby_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_cnt >= CW'(T_DF)) |-> !dout_en);

  p_outoff_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cnt >= CW'(T_DF)) |-> !dout_en);

  p_program_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_cnt >= CW'(T_DF)) |-> !dout_en);

  p_drive_onset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(!ce_n && !oe_n));

  p_id_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && (id_cnt > CW'(T_CE))) |-> (^dout == 1'b1));
endmodule

bind eprom_ctl eprom_ctl_chk #(.ADDR_W(ADDR_W), .T_CE(T_CE), .T_DF(T_DF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .pgm_n   (pgm_n),
  .vpp_hv  (vpp_hv),
  .a9_hv   (a9_hv),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/sim_eprom_ctl.sv
`timescale 1ns/1ps
module sim_eprom_ctl;
  localparam int ADDR_W = 14;
  localparam int T_CE = 4;
  localparam int T_OE = 2;
  localparam int T_DF = 2;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, pgm_n, vpp_hv, a9_hv, erase;
  logic [ADDR_W-1:0] addr;
  logic [7:0] din, dout;
  logic dout_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit         q_en[$];
  logic [7:0] q_d[$];
  string      q_r[$];

  always #10 clk = ~clk;

  eprom_ctl #(.ADDR_W(ADDR_W), .ARRAY_AW(8), .T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hv(vpp_hv), .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit en, input logic [7:0] d, input string req);
    q_en.push_back(en);
    q_d.push_back(d);
    q_r.push_back(req);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q_en.size() > 0) begin
        bit e; logic [7:0] d; string r;
        e = q_en.pop_front(); d = q_d.pop_front(); r = q_r.pop_front();
        checks++;
        if (dout_en !== e || (e && dout !== d)) begin
          failures++;
          $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                   r, dout_en, dout, e, d);
        end
      end
    end
  end

  task automatic check_parity(input string req);
    checks++;
    if ((^dout) !== 1'b1) begin
      failures++;
      $display("FAIL %s: parity of %02h is %0b expected 1", req, dout, ^dout);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hv = 0; a9_hv = 0;
    erase = 0; addr = '0; din = '0;
    step(3);
    expect_out(1'b0, 8'h00, "R1 in reset");
    checks++;
    if (dout !== 8'h00) begin failures++; $display("FAIL R1: dout=%02h expected 00", dout); end
    rst_n = 1;
    step(1);
    expect_out(1'b0, 8'h00, "R1 after reset");

    // R2/R3: read erased location after chip select falls
    addr = 14'd5; ce_n = 0; oe_n = 0;
    step(T_CE);     expect_out(1'b0, 8'h00, "R3 ce access not yet");
    step(1);        expect_out(1'b1, 8'hFF, "R3 ce access / R1 erased / R2 read");

    // R9/R4: program mode, output gate high
    oe_n = 1; vpp_hv = 1; pgm_n = 0; din = 8'hA5;
    step(1);        expect_out(1'b1, 8'hFF, "R4 hold during float delay");
    step(1);        expect_out(1'b0, 8'h00, "R9 program floats");
    din = 8'h5F;
    step(1);

    // R11/R3: verify read after output gate falls
    pgm_n = 1; oe_n = 0;
    step(T_OE);     expect_out(1'b0, 8'h00, "R3 oe access not yet");
    step(1);        expect_out(1'b1, 8'h05, "R9 only clears / R11 verify");

    // R13: aliasing
    addr = 14'h0105;
    step(1);        expect_out(1'b1, 8'h05, "R13 alias");
    addr = 14'h0006;
    step(1);        expect_out(1'b1, 8'hFF, "R2 other address");

    // R7/R8: identifier
    a9_hv = 1; addr = 14'h0000;
    step(1);        expect_out(1'b1, 8'h01, "R7 manufacturer"); check_parity("R8 manufacturer");
    addr = 14'h3FF1;
    step(1);        expect_out(1'b1, 8'h16, "R7 device"); check_parity("R8 device");
    addr = 14'h3FF0;
    step(1);        expect_out(1'b1, 8'h01, "R7 high bits ignored");

    // R5: standby with output gate low
    a9_hv = 0; vpp_hv = 0; ce_n = 1;
    step(1);        expect_out(1'b1, 8'h01, "R4 standby hold");
    step(1);        expect_out(1'b0, 8'h00, "R5 standby floats");
    step(3);        expect_out(1'b0, 8'h00, "R5 standby stays off");

    // R10: inhibit
    vpp_hv = 1; pgm_n = 0; addr = 14'h0006; din = 8'h00;
    step(3);        expect_out(1'b0, 8'h00, "R10 inhibit floats");
    vpp_hv = 0; pgm_n = 1; ce_n = 0;
    step(T_CE);     expect_out(1'b0, 8'h00, "R3 ce access not yet 2");
    step(1);        expect_out(1'b1, 8'hFF, "R10 inhibit left array");

    // R6: output off
    oe_n = 1;
    step(2);        expect_out(1'b0, 8'h00, "R6 output off floats");
    oe_n = 0;
    step(T_OE + 1); expect_out(1'b1, 8'hFF, "R6 return");

    // R9: program with output gate low
    vpp_hv = 1; pgm_n = 0; din = 8'h3C;
    step(1);        expect_out(1'b1, 8'hFF, "R4 program hold");
    step(1);        expect_out(1'b0, 8'h00, "R9 program floats with oe low");
    pgm_n = 1;
    step(1);        expect_out(1'b1, 8'h3C, "R9 programmed value");

    // R12: erase
    erase = 1;
    step(1);
    erase = 0;
    step(1);        expect_out(1'b1, 8'hFF, "R12 erased");
    addr = 14'h0005;
    step(1);        expect_out(1'b1, 8'hFF, "R12 erased other");

    step(2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule